// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Store

This block is a synthesizable model of a small serial EEPROM slave that holds an array of 16-bit words. A host selects it with a chip-select line, shifts bits in on a serial data input with each rising edge of a serial clock, and receives read data or a program-status flag on a serial data output. The serial pins are sampled in the block's own clock domain. A rising edge on the serial clock is detected one system clock after the pin goes high, so the serial clock must stay well below the system clock.

Each command is a start bit of 1, a 2-bit operation code and an address of `ADDR_W` bits, most significant bit first. Some commands also carry a 16-bit data word. A write-enable latch guards every command that changes the array. Program commands take effect on the sampling edge of their final bit. A timer then holds the device busy for `BUSY_CYC` system clock cycles. Once chip select is raised again, the host can poll the output for the ready flag.

The controller has seven named states:
- `ST_IDLE`: chip select is low.
- `ST_WAIT_START`: selected, hunting for the start bit, and showing status on the output.
- `ST_OPCODE`: taking the two code bits.
- `ST_ADDR`: taking the address bits.
- `ST_DATA`: taking the 16 data bits.
- `ST_READ`: shifting out the dummy zero and then the word.
- `ST_DONE`: the command is complete and further clocks are ignored.

The transitions are:
- Any state goes to `ST_IDLE` when chip select is low.
- `ST_IDLE` goes to `ST_WAIT_START` when chip select is high.
- `ST_WAIT_START` goes to `ST_OPCODE` on a sampled 1 while not busy.
- `ST_OPCODE` goes to `ST_ADDR` after two bits.
- `ST_ADDR` goes to one of three states on its last bit: `ST_READ` for a read, `ST_DATA` for the two commands that carry a word, and `ST_DONE` otherwise.
- `ST_DATA` goes to `ST_DONE` after 16 bits.
- `ST_READ` goes to `ST_DONE` on the edge after the last data bit.

Top module: `three_wire_eeprom`

## Requirements
- R1: A command starts with a sampled 1 in `ST_WAIT_START`. Zeros sampled before it are ignored. The 2-bit code and the `ADDR_W`-bit address then follow, most significant bit first.
- R2: Code 2'b10 reads. After the sampling edge of the last address bit, the output shows 0. Each following serial clock rise then presents the next word bit, from bit 15 down to bit 0.
- R3: Code 2'b01 takes 16 data bits, most significant first, and stores them at the address when writing is enabled.
- R4: Code 2'b11 sets the addressed word to 16'hFFFF when writing is enabled. All other words are left unchanged.
- R5: Code 2'b00 is decoded by the two top address bits, and the lower address bits are don't-care. The top bits select as follows:
  - 2'b11 enables writing.
  - 2'b10 sets every word to 16'hFFFF.
  - 2'b01 takes 16 data bits and stores them in every word.
  - 2'b00 disables writing.
- R6: The write-enable latch is cleared by reset and by the disable command. While it is clear, the write, erase, fill and clear-all commands change no word and start no busy period.
- R7: While chip select is low, the output is 0 and the device returns to `ST_IDLE`. A command cut short by dropping chip select has no effect.
- R8: In `ST_WAIT_START` the output shows 0 while busy and 1 when ready. An enabled program command keeps the device busy for `BUSY_CYC` cycles after its final bit.
- R9: A start bit sampled while busy is ignored, and the device stays in `ST_WAIT_START`.
- R10: After reset every word reads 16'hFFFF and the device reports ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock; the rising edge samples input and launches output |
| sdi | input | 1 | Serial data into the device |
| sdo | output | 1 | Serial data out: read data, or busy/ready status |

## Verification
The assertions take for granted that `cs`, `sck` and `sdi` are synchronous to `clk`. They also assume that each `sck` level is held for at least two system cycles, so that every serial edge is seen exactly once. The bench drives all three pins only on the falling edge of `clk` and holds each serial clock phase for two cycles. It samples `sdo` only after the rise has propagated through the edge detector and the state register. It waits for the ready flag between program commands, except where it deliberately sends a start bit into a busy period.

// File: rtl/twe_pkg.sv
package twe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_START,
        ST_OPCODE,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_DONE
    } twe_state_t;

    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    localparam logic [1:0] EXT_WDIS = 2'b00;
    localparam logic [1:0] EXT_FILL = 2'b01;
    localparam logic [1:0] EXT_CLR  = 2'b10;
    localparam logic [1:0] EXT_WENA = 2'b11;

endpackage

// File: rtl/twe_sck_edge.sv
module twe_sck_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    output logic rise
);
    logic sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    assign rise = sck && !sck_q;

endmodule

// File: rtl/twe_busy_timer.sv
module twe_busy_timer #(
    parameter int BUSY_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int BW = $clog2(BUSY_CYC + 1);

    logic [BW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (start)        cnt_q <= BW'(BUSY_CYC);
        else if (cnt_q != '0)  cnt_q <= cnt_q - BW'(1);
    end

    assign busy = (cnt_q != '0);

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= BW'(BUSY_CYC)); // R8

    AST_BUSY_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> (cnt_q < $past(cnt_q))); // R8

endmodule

// File: rtl/twe_word_array.sv
module twe_word_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              wall,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '1;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wall || (we && (waddr == ADDR_W'(i)))) words[i] <= wdata;
            end
        end
    end

    assign rdata = words[raddr];

    AST_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && wall)); // R5

endmodule

// File: rtl/three_wire_eeprom.sv
module three_wire_eeprom
    import twe_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 16,
    parameter int BUSY_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sck,
    input  logic sdi,
    output logic sdo
);
    localparam int CNT_MAX = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    twe_state_t        state, state_nxt;
    logic              rise;
    logic              busy;
    logic [1:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-2:0] data_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] rd_sh;
    logic [CNT_W-1:0]  rd_cnt;
    logic              wen_q;

    logic [ADDR_W-1:0] addr_full;
    logic [DATA_W-1:0] data_full;
    logic [1:0]        ext_addr;
    logic [1:0]        ext_data;
    logic              last_addr;
    logic              last_data;
    logic              mem_we, mem_wall;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;

    twe_sck_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sck   (sck),
        .rise  (rise)
    );

    twe_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mem_we || mem_wall),
        .busy  (busy)
    );

    twe_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .wall  (mem_wall),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (addr_full),
        .rdata (mem_rdata)
    );

    assign addr_full = {addr_q[ADDR_W-2:0], sdi};
    assign data_full = {data_q, sdi};
    assign ext_addr  = addr_full[ADDR_W-1 -: 2];
    assign ext_data  = addr_q[ADDR_W-1 -: 2];
    assign last_addr = rise && (state == ST_ADDR) && (cnt_q == CNT_W'(ADDR_W - 1));
    assign last_data = rise && (state == ST_DATA) && (cnt_q == CNT_W'(DATA_W - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Next-state decode
    always_comb begin
        state_nxt = state;
        if (!cs) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:       state_nxt = ST_WAIT_START;
                ST_WAIT_START: if (rise && sdi && !busy) state_nxt = ST_OPCODE;
                ST_OPCODE:     if (rise && cnt_q == CNT_W'(1)) state_nxt = ST_ADDR;
                ST_ADDR: begin
                    if (last_addr) begin
                        if (op_q == OP_READ)
                            state_nxt = ST_READ;
                        else if (op_q == OP_WRITE || (op_q == OP_EXT && ext_addr == EXT_FILL))
                            state_nxt = ST_DATA;
                        else
                            state_nxt = ST_DONE;
                    end
                end
                ST_DATA:       if (last_data) state_nxt = ST_DONE;
                ST_READ:       if (rise && rd_cnt == CNT_W'(DATA_W)) state_nxt = ST_DONE;
                default:       state_nxt = state;
            endcase
        end
    end

    // Shift registers and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= '0;
            addr_q <= '0;
            data_q <= '0;
            cnt_q  <= '0;
            rd_sh  <= '0;
            rd_cnt <= '0;
        end else if (!cs) begin
            cnt_q  <= '0;
            rd_cnt <= '0;
        end else begin
            unique case (state)
                ST_OPCODE: if (rise) begin
                    op_q  <= {op_q[0], sdi};
                    cnt_q <= (cnt_q == CNT_W'(1)) ? '0 : cnt_q + CNT_W'(1);
                end
                ST_ADDR: if (rise) begin
                    addr_q <= addr_full;
                    cnt_q  <= last_addr ? '0 : cnt_q + CNT_W'(1);
                    if (last_addr && op_q == OP_READ) begin
                        rd_sh  <= mem_rdata;
                        rd_cnt <= '0;
                    end
                end
                ST_DATA: if (rise) begin
                    data_q <= data_full[DATA_W-2:0];
                    cnt_q  <= cnt_q + CNT_W'(1);
                end
                ST_READ: if (rise) begin
                    if (rd_cnt != '0) rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
                    rd_cnt <= rd_cnt + CNT_W'(1);
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // Write-enable latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wen_q <= 1'b0;
        else if (cs && last_addr && op_q == OP_EXT) begin
            if (ext_addr == EXT_WENA)      wen_q <= 1'b1;
            else if (ext_addr == EXT_WDIS) wen_q <= 1'b0;
        end
    end

    // Program execution
    always_comb begin
        mem_we    = 1'b0;
        mem_wall  = 1'b0;
        mem_waddr = addr_q;
        mem_wdata = '1;
        if (cs && last_addr) begin
            mem_waddr = addr_full;
            if (op_q == OP_ERASE)                            mem_we   = wen_q;
            else if (op_q == OP_EXT && ext_addr == EXT_CLR)  mem_wall = wen_q;
        end else if (cs && last_data) begin
            mem_wdata = data_full;
            if (op_q == OP_WRITE)                            mem_we   = wen_q;
            else if (op_q == OP_EXT && ext_data == EXT_FILL) mem_wall = wen_q;
        end
    end

    // Output
    always_comb begin
        unique case (state)
            ST_WAIT_START: sdo = !busy;
            ST_READ:       sdo = (rd_cnt == '0) ? 1'b0 : rd_sh[DATA_W-1];
            default:       sdo = 1'b0;
        endcase
    end

    AST_CS_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (state == ST_IDLE)); // R7

    AST_READ_DUMMY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_ADDR && state == ST_READ) |-> !sdo); // R2

    AST_PROG_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_wall) |=> busy); // R8

    AST_BUSY_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_START && busy) |=> (state != ST_OPCODE)); // R9

    AST_WEN_ONLY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (wen_q != $past(wen_q)) |-> ($past(state) == ST_ADDR)); // R5

    AST_PROG_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wen_q)); // R6

endmodule

// File: tb/three_wire_eeprom_tb.sv
module three_wire_eeprom_tb;
    localparam int AW   = 6;
    localparam int DW   = 16;
    localparam int BUSY = 40;
    localparam int NW   = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0;
    logic sck = 1'b0;
    logic sdi = 1'b0;
    logic sdo;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    three_wire_eeprom #(.ADDR_W(AW), .DATA_W(DW), .BUSY_CYC(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .sdi(sdi), .sdo(sdo)
    );

    function automatic logic [DW-1:0] pat(int a);
        return (DW'(a) * 16'h0413) ^ 16'hA5C3;
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(logic b);
        @(negedge clk); sck = 1'b0; sdi = b;
        repeat (2) @(negedge clk);
        sck = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic cs_off();
        @(negedge clk); cs = 1'b0; sck = 1'b0; sdi = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic cs_on();
        @(negedge clk); cs = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_cmd(logic [1:0] op, logic [AW-1:0] a);
        pulse(1'b1);
        pulse(op[1]);
        pulse(op[0]);
        for (int i = AW - 1; i >= 0; i--) pulse(a[i]);
    endtask

    task automatic send_word(logic [DW-1:0] d);
        for (int i = DW - 1; i >= 0; i--) pulse(d[i]);
    endtask

    task automatic wait_ready();
        int n;
        cs_on();
        n = 0;
        while (sdo !== 1'b1 && n < 4 * BUSY) begin
            @(negedge clk);
            n++;
        end
        cs_off();
    endtask

    task automatic do_read(logic [AW-1:0] a, int zeros, output logic [DW-1:0] d);
        cs_on();
        for (int z = 0; z < zeros; z++) pulse(1'b0);
        send_cmd(2'b10, a);
        check("R2 dummy zero", {15'b0, sdo}, 16'h0000);
        d = '0;
        for (int i = 0; i < DW; i++) begin
            pulse(1'b0);
            d = {d[DW-2:0], sdo};
        end
        cs_off();
    endtask

    task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
        cs_on();
        send_cmd(2'b01, a);
        send_word(d);
        cs_off();
        wait_ready();
    endtask

    task automatic ext_cmd(logic [1:0] sub, logic with_data, logic [DW-1:0] d);
        cs_on();
        send_cmd(2'b00, {sub, 4'b1010});
        if (with_data) send_word(d);
        cs_off();
        wait_ready();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] rd;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7 / R10: reset state
        check("R7 sdo low while deselected", {15'b0, sdo}, 16'h0000);
        cs_on();
        check("R10 ready after reset", {15'b0, sdo}, 16'h0001);
        cs_off();
        do_read(0, 0, rd);  check("R10 erased word 0", rd, 16'hFFFF);
        do_read(21, 0, rd); check("R10 erased word 21", rd, 16'hFFFF);
        do_read(63, 0, rd); check("R10 erased word 63", rd, 16'hFFFF);

        // R6: write without enable is ignored and starts no busy period
        cs_on(); send_cmd(2'b01, 5); send_word(16'h1234); cs_off();
        cs_on();
        check("R6 no busy when disabled", {15'b0, sdo}, 16'h0001);
        cs_off();
        do_read(5, 0, rd); check("R6 disabled write ignored", rd, 16'hFFFF);

        // R5: enable with don't-care low address bits; R8 busy then ready
        ext_cmd(2'b11, 1'b0, '0);
        cs_on(); send_cmd(2'b01, 9); send_word(16'hBEEF); cs_off();
        cs_on();
        check("R8 busy after write", {15'b0, sdo}, 16'h0000);
        repeat (BUSY + 5) @(negedge clk);
        check("R8 ready after busy", {15'b0, sdo}, 16'h0001);
        cs_off();
        do_read(9, 0, rd); check("R3 write word 9", rd, 16'hBEEF);

        // R9: start bit during busy is ignored
        cs_on(); send_cmd(2'b01, 10); send_word(16'h5555); cs_off();
        cs_on();
        pulse(1'b1); pulse(1'b1); pulse(1'b0);
        repeat (BUSY + 5) @(negedge clk);
        check("R9 start ignored while busy", {15'b0, sdo}, 16'h0001);
        cs_off();

        // R3 / R1: full sweep write and read back
        for (int a = 0; a < NW; a++) do_write(AW'(a), pat(a));
        for (int a = 0; a < NW; a++) begin
            do_read(AW'(a), 0, rd);
            check("R3 sweep readback", rd, pat(a));
        end

        // R4: erase one word
        cs_on(); send_cmd(2'b11, 7); cs_off(); wait_ready();
        do_read(7, 0, rd); check("R4 erased word 7", rd, 16'hFFFF);
        do_read(6, 0, rd); check("R4 neighbour 6 kept", rd, pat(6));
        do_read(8, 0, rd); check("R4 neighbour 8 kept", rd, pat(8));

        // R1: leading zeros before start bit
        do_read(6, 3, rd); check("R1 leading zeros ignored", rd, pat(6));

        // R7: aborted write has no effect
        cs_on(); send_cmd(2'b01, 12);
        for (int i = 0; i < 8; i++) pulse(1'b0);
        cs_off(); wait_ready();
        do_read(12, 0, rd); check("R7 aborted write", rd, pat(12));

        // R5: fill all words
        ext_cmd(2'b01, 1'b1, 16'h3C96);
        for (int a = 0; a < NW; a++) begin
            do_read(AW'(a), 0, rd);
            check("R5 fill all", rd, 16'h3C96);
        end

        // R5: clear all words
        ext_cmd(2'b10, 1'b0, '0);
        for (int a = 0; a < NW; a += 5) begin
            do_read(AW'(a), 0, rd);
            check("R5 clear all", rd, 16'hFFFF);
        end

        // R6: disable then write is ignored
        ext_cmd(2'b00, 1'b0, '0);
        cs_on(); send_cmd(2'b01, 3); send_word(16'h0F0F); cs_off();
        cs_on();
        check("R6 no busy after disable", {15'b0, sdo}, 16'h0001);
        cs_off();
        do_read(3, 0, rd); check("R6 write after disable ignored", rd, 16'hFFFF);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule